// File: doc/BRIEF.md
# Multi-Pattern Transceiver Test Word Generator

This block drives the parallel transmit side of a serial transceiver lane with test data. On every clock it registers one parallel word that holds the next stretch of a chosen test sequence. Four pseudo-random binary sequences (orders 7, 15, 23 and 31) and two square-wave patterns, at two different periods, can be chosen. The choice is made at runtime through a select input. The word width is fixed at build time to 16 or 20 bits. The block advances each sequence by one bit position for every bit of the word, so a full word's worth of sequence is produced in each cycle.

An invert control flips every bit of the outgoing word. This lets a lane with swapped differential wiring be matched, and the underlying sequence is left undisturbed. Each generator has its own synchronous reset, so one lane can be restarted without touching its neighbours. Bit 0 of the word is the first bit on the line.

Top module: `txpat_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `tx_word` is cleared to all zeros on that edge. The first test word appears at the first rising edge at which `rst` is low.
- R2: `tx_word` is registered. The word loaded at an edge is computed from `pat_sel` and `invert` as they stand at that edge. Bit 0 is the earliest sequence bit and bit WORD_W-1 is the latest. Select codes: 0 = order-7 PRBS, 1 = order-15, 2 = order-23, 3 = order-31, 4 = fast square wave, 5 = slow square wave.
- R3: Code 0 emits the sequence o(k) = o(k-7) XOR o(k-6). Every bit before the start of the sequence counts as 1 (all-ones seed).
- R4: Code 1 emits o(k) = o(k-15) XOR o(k-14), with an all-ones seed.
- R5: Code 2 emits o(k) = o(k-23) XOR o(k-18), with an all-ones seed.
- R6: Code 3 emits o(k) = o(k-31) XOR o(k-28), with an all-ones seed.
- R7: Code 4 emits the repeating group 1,1,0,0 starting at sequence bit 0. For a 16-bit word that is 16'h3333 in every cycle.
- R8: Code 5 emits ten 1s followed by ten 0s, repeating, and its phase carries across word boundaries. For a 16-bit word the first two words are 16'h03FF and 16'h3FF0.
- R9: When `pat_sel` differs from its value at the previous edge, the newly selected pattern restarts from sequence bit 0, meaning the all-ones seed or phase zero.
- R10: With `invert` high, every bit of the word is the complement of the non-inverted value. The sequence position advances exactly as it would without inversion.
- R11: Codes 6 and 7 emit an all-zero word, or an all-ones word when `invert` is high.
- R12: While `pat_sel` is held, each word continues the sequence from the bit after the last bit of the previous word, with no gap and no repeat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset for this lane |
| pat_sel | input | 3 | Pattern select code |
| invert | input | 1 | Polarity inversion of the output word |
| tx_word | output | WORD_W | Registered parallel test word, bit 0 sent first |

## Verification
Several properties are checked on every cycle. The order-7 and order-15 recurrences are checked inside each word, with inversion taken into account. The fast square wave must hold its fixed word. Unused codes must give a constant word, and the output must be clear after reset. Other behaviour depends on history across cycles and can only be shown by the bench's scenarios. This covers the longer polynomials whose taps reach past one word, the slow square wave's phase across words, continuity of a sequence across word boundaries, and the restart after a select change or a mid-run reset. For these, the bench runs its own bit-serial model of every pattern across long runs and against literal words.

// File: rtl/txpat_pkg.sv
package txpat_pkg;

  localparam int SEL_W    = 3;
  localparam int NUM_PRBS = 4;

  // square-wave phase span covers both periods (4 and 20 bits)
  localparam int CLK_SPAN   = 20;
  localparam int SLOW_HALF  = 10;
  localparam int PHASE_W    = 6;

  typedef enum logic [SEL_W-1:0] {
    PAT_PRBS7  = 3'd0,
    PAT_PRBS15 = 3'd1,
    PAT_PRBS23 = 3'd2,
    PAT_PRBS31 = 3'd3,
    PAT_FAST   = 3'd4,
    PAT_SLOW   = 3'd5
  } pat_e;

  function automatic int prbs_order(input int idx);
    case (idx)
      0:       return 7;
      1:       return 15;
      2:       return 23;
      default: return 31;
    endcase
  endfunction

  function automatic int prbs_tap(input int idx);
    case (idx)
      0:       return 6;
      1:       return 14;
      2:       return 18;
      default: return 28;
    endcase
  endfunction

endpackage

// File: rtl/txpat_prbs.sv
module txpat_prbs #(
  parameter int ORDER  = 7,
  parameter int TAP    = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              advance,
  output logic [WORD_W-1:0] bits_o
);

  logic [ORDER-1:0] state_q;
  logic [ORDER-1:0] walk;
  logic             fb;

  // unrolled WORD_W steps of the shift register, newest bit in walk[0]
  always_comb begin
    walk   = restart ? '1 : state_q;
    fb     = 1'b0;
    bits_o = '0;
    for (int j = 0; j < WORD_W; j++) begin
      fb        = walk[ORDER-1] ^ walk[TAP-1];
      bits_o[j] = fb;
      walk      = {walk[ORDER-2:0], fb};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '1;
    end else if (advance) begin
      state_q <= walk;
    end
  end

endmodule

// File: rtl/txpat_clkpat.sv
module txpat_clkpat
  import txpat_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              advance,
  input  logic              slow,
  output logic [WORD_W-1:0] bits_o
);

  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] start;
  logic [PHASE_W-1:0] phase_nxt;
  logic [PHASE_W-1:0] idx;

  always_comb begin
    start = restart ? '0 : phase_q;
    idx   = '0;
    for (int j = 0; j < WORD_W; j++) begin
      idx = start + PHASE_W'(j);
      if (idx >= PHASE_W'(CLK_SPAN)) idx = idx - PHASE_W'(CLK_SPAN);
      bits_o[j] = slow ? (idx < PHASE_W'(SLOW_HALF)) : ~idx[1];
    end
    phase_nxt = start + PHASE_W'(WORD_W);
    if (phase_nxt >= PHASE_W'(CLK_SPAN)) phase_nxt = phase_nxt - PHASE_W'(CLK_SPAN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (advance) begin
      phase_q <= phase_nxt;
    end
  end

endmodule

// File: rtl/txpat_gen.sv
module txpat_gen
  import txpat_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  pat_sel,
  input  logic              invert,
  output logic [WORD_W-1:0] tx_word
);

  logic [SEL_W-1:0]  sel_q;
  logic              restart;
  logic [WORD_W-1:0] prbs_bits [NUM_PRBS];
  logic [WORD_W-1:0] sq_bits;
  logic [WORD_W-1:0] raw_word;
  logic              sq_active;

  assign restart   = (pat_sel != sel_q);
  assign sq_active = (pat_sel == PAT_FAST) || (pat_sel == PAT_SLOW);

  for (genvar g = 0; g < NUM_PRBS; g++) begin : g_prbs
    txpat_prbs #(
      .ORDER  (prbs_order(g)),
      .TAP    (prbs_tap(g)),
      .WORD_W (WORD_W)
    ) u_prbs (
      .clk     (clk),
      .rst     (rst),
      .restart (restart),
      .advance (pat_sel == SEL_W'(g)),
      .bits_o  (prbs_bits[g])
    );
  end

  txpat_clkpat #(
    .WORD_W (WORD_W)
  ) u_sq (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .advance (sq_active),
    .slow    (pat_sel == PAT_SLOW),
    .bits_o  (sq_bits)
  );

  always_comb begin
    case (pat_sel)
      PAT_PRBS7:  raw_word = prbs_bits[0];
      PAT_PRBS15: raw_word = prbs_bits[1];
      PAT_PRBS23: raw_word = prbs_bits[2];
      PAT_PRBS31: raw_word = prbs_bits[3];
      PAT_FAST,
      PAT_SLOW:   raw_word = sq_bits;
      default:    raw_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    sel_q <= pat_sel;
    if (rst) begin
      tx_word <= '0;
    end else begin
      tx_word <= raw_word ^ {WORD_W{invert}};
    end
  end

endmodule

// File: rtl/txpat_chk.sv
module txpat_chk
  import txpat_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [SEL_W-1:0]  pat_sel,
  input logic              invert,
  input logic [WORD_W-1:0] tx_word
);

  function automatic logic rec_ok(input logic [WORD_W-1:0] w, input int n,
                                  input int t, input logic inv);
    logic ok;
    ok = 1'b1;
    for (int j = n; j < WORD_W; j++) begin
      if ((w[j] ^ w[j-n] ^ w[j-t]) != inv) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic [WORD_W-1:0] fast_word();
    logic [WORD_W-1:0] w;
    for (int j = 0; j < WORD_W; j++) w[j] = ((j % 4) < 2);
    return w;
  endfunction

  assert_cleared_R1: assert property (@(posedge clk)
    rst |=> tx_word == '0);

  assert_prbs7_rec_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pat_sel) == 3'd0)
      |-> rec_ok(tx_word, 7, 6, $past(invert)));

  assert_prbs15_rec_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pat_sel) == 3'd1)
      |-> rec_ok(tx_word, 15, 14, $past(invert)));

  assert_fast_word_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pat_sel) == 3'd4)
      |-> tx_word == (fast_word() ^ {WORD_W{$past(invert)}}));

  assert_unused_code_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pat_sel) > 3'd5)
      |-> tx_word == {WORD_W{$past(invert)}});

endmodule

bind txpat_gen txpat_chk #(.WORD_W(WORD_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .pat_sel (pat_sel),
  .invert  (invert),
  .tx_word (tx_word)
);

// File: tb/tb_txpat_gen.sv
`timescale 1ns/1ps
module tb_txpat_gen;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   pat_sel = 3'd0;
  logic         invert = 1'b0;
  logic [W-1:0] tx_word;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference model state
  logic [30:0] hist;
  int          gidx;
  logic [2:0]  prev_sel;

  always #2.5 clk = ~clk;

  txpat_gen #(.WORD_W(W)) dut (
    .clk     (clk),
    .rst     (rst),
    .pat_sel (pat_sel),
    .invert  (invert),
    .tx_word (tx_word)
  );

  task automatic check(input logic [W-1:0] exp, input string tag);
    n_chk++;
    if (tx_word !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, tx_word, exp);
    end
  endtask

  task automatic model_reset(input logic [2:0] s);
    hist     = '1;
    gidx     = 0;
    prev_sel = s;
  endtask

  task automatic model_word(input logic [2:0] s, input logic inv,
                            output logic [W-1:0] exp, output string tag);
    int  n, t;
    logic b;
    bit  rs;
    rs = (s != prev_sel);
    if (rs) begin
      hist = '1;
      gidx = 0;
    end
    prev_sel = s;
    n = 7; t = 6;
    case (s)
      3'd1: begin n = 15; t = 14; end
      3'd2: begin n = 23; t = 18; end
      3'd3: begin n = 31; t = 28; end
      default: ;
    endcase
    for (int k = 0; k < W; k++) begin
      if (s <= 3'd3) begin
        b = hist[n-1] ^ hist[t-1];
        hist = {hist[29:0], b};
      end else if (s == 3'd4) begin
        b = ((gidx % 4) < 2);
      end else if (s == 3'd5) begin
        b = ((gidx % 20) < 10);
      end else begin
        b = 1'b0;
      end
      exp[k] = b ^ inv;
      gidx++;
    end
    case (s)
      3'd0: tag = "R3";
      3'd1: tag = "R4";
      3'd2: tag = "R5";
      3'd3: tag = "R6";
      3'd4: tag = "R7";
      3'd5: tag = "R8";
      default: tag = "R11";
    endcase
    tag = {tag, rs ? " R9" : " R12", inv ? " R10" : "", " R2"};
  endtask

  task automatic step(input logic [2:0] s, input logic inv);
    logic [W-1:0] exp;
    string        tag;
    pat_sel = s;
    invert  = inv;
    model_word(s, inv, exp, tag);
    @(negedge clk);
    check(exp, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: cleared during reset
    repeat (3) begin
      @(negedge clk);
      check('0, "R1 in reset");
    end
    rst = 1'b0;
    model_reset(3'd0);

    // sweep every select code, inversion on some words
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 40; k++) step(3'(s), (k % 7) == 3);
    end

    // literal words, LSB-first ordering
    step(3'd5, 1'b0);
    check(16'h03FF, "R8 R2 first slow word");
    step(3'd5, 1'b0);
    check(16'h3FF0, "R8 second slow word");
    step(3'd4, 1'b0);
    check(16'h3333, "R7 R2 fast word");
    step(3'd4, 1'b1);
    check(16'hCCCC, "R10 inverted fast word");
    step(3'd6, 1'b1);
    check(16'hFFFF, "R11 unused code inverted");

    // restart when returning to a pattern
    for (int k = 0; k < 5; k++) step(3'd0, 1'b0);
    for (int k = 0; k < 3; k++) step(3'd5, 1'b0);
    for (int k = 0; k < 5; k++) step(3'd0, 1'b0);

    // long run of the longest sequence, inversion toggling
    for (int k = 0; k < 300; k++) step(3'd3, (k / 50) % 2 == 1);

    // mid-run reset of this lane
    for (int k = 0; k < 10; k++) step(3'd2, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    check('0, "R1 mid-run reset");
    rst = 1'b0;
    model_reset(3'd2);
    for (int k = 0; k < 10; k++) step(3'd2, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule